// File: doc/BRIEF.md
# Triplicated Configuration Register Bank

This block is the byte-wide configuration store of a data converter. A register-access front end, which lies outside the block, presents an 8-bit address, 8-bit write data and a write strobe. The block returns read data combinationally from the current address. Eight writable registers, at addresses 0x00 to 0x07, are each kept in three independent copies. All three copies take every write together. Every read, and every field exported to the converter, comes from the bitwise majority of the three copies.

The copies are compared against each other on every cycle. A read-only flag goes high while any bit of any copy disagrees with the others. Writing a register again with a value restores agreement for that register.

The block also carries the following:
- reserved bits held at fixed values;
- a self-clearing soft reset bit;
- a read-only temperature code register, with the code supplied on a port;
- eight read-only bytes of die identifier and a revision byte, also supplied on ports;
- a test input that flips a single stored bit in a single copy, so that the protection can be exercised.

Top module: `cfg_triplex_bank`

## Requirements
- R1: After reset, registers 0x00, 0x01, 0x02 and 0x07 read 0x00. Register 0x05 reads 0x20 and register 0x06 reads 0x04. Register 0x03 reads {7'b0, OFFSET_DEF[8]} and register 0x04 reads OFFSET_DEF[7:0]. `copy_err` is 0.
- R2: A write to a register in 0x00..0x07 is read back on the next cycle, with these reserved bits forced:
  - 0x01 bits 2:0 read 0;
  - 0x02 bit 2 reads 0;
  - 0x03 bit 1 reads 0;
  - 0x05 bit 0 reads 0;
  - 0x05 bit 5 reads 1.
- R3: A write to 0x01 with data bit 2 set discards that write's data. On the next cycle all of registers 0x00..0x07 hold their R1 defaults, and bit 2 reads 0.
- R4: Writes to any address from 0x08 to 0xFF change nothing. Reads of addresses that are not listed in R2 or R5 return 0x00.
- R5: Reads of the read-only addresses return the following:
  - 0x08 returns `temp_code`;
  - 0x09 returns {7'b0, copy_err};
  - 0x17+k, for k = 0..7, returns `die_id[8k+7:8k]`;
  - 0x1F returns `die_rev`.
- R6: `gain_trim` equals {reg 0x00, reg 0x01[7:4]}, and `four_wire` equals reg 0x01 bit 3.
- R7: When `tamper_en` is high at a clock edge, bit `tamper_bit` of register `tamper_reg` is inverted in copy `tamper_copy`. The values 0..2 of `tamper_copy` select a copy and 3 selects none. After the edge, `copy_err` is 1, while reads and exported fields still show the majority value.
- R8: A write updates all three copies of a register, which clears any disagreement in that register. `copy_err` never rises unless `tamper_en` was high at the preceding edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| temp_code | input | 8 | Temperature code from the sensor |
| die_id | input | 64 | Die identifier |
| die_rev | input | 8 | Revision byte |
| tamper_en | input | 1 | Test only: flip one stored bit |
| tamper_copy | input | 2 | Test only: copy to flip (3 = none) |
| tamper_reg | input | 3 | Test only: register index to flip |
| tamper_bit | input | 3 | Test only: bit position to flip |
| copy_err | output | 1 | Copies disagree somewhere |
| gain_trim | output | 12 | 12-bit gain trim word |
| four_wire | output | 1 | Serial mode select, 1 = 4-pin |

## Verification
A corrupted copy that the voter failed to outvote would show up immediately: the read-back byte at that address would be wrong, and so would `gain_trim` or `four_wire`, in the cycle after the flip. The sweep flips every bit of every register in each copy in turn. After each flip it checks three things in the following cycle: `copy_err` is high, address 0x09 reads 1, and the majority read is unchanged. A wrong reserved-bit mask, soft-reset path or address decode would show on the first read-back after the write concerned, because every address is read after the write sweeps.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;

  localparam int NREG   = 8;
  localparam int IDX_W  = $clog2(NREG);
  localparam int DW     = 8;
  localparam int NCOPY  = 3;

  typedef logic [DW-1:0] byte_t;
  typedef logic [NREG-1:0][DW-1:0] bank_t;

  // bits that always store 0
  function automatic byte_t clr_mask(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd1:    clr_mask = 8'h07;
      3'd2:    clr_mask = 8'h04;
      3'd3:    clr_mask = 8'h02;
      3'd5:    clr_mask = 8'h01;
      default: clr_mask = 8'h00;
    endcase
  endfunction

  // bits that always store 1
  function automatic byte_t set_mask(input logic [IDX_W-1:0] idx);
    set_mask = (idx == 3'd5) ? 8'h20 : 8'h00;
  endfunction

  function automatic byte_t default_of(input logic [IDX_W-1:0] idx,
                                       input logic [8:0] offset_def);
    case (idx)
      3'd3:    default_of = {7'b0, offset_def[8]};
      3'd4:    default_of = offset_def[7:0];
      3'd5:    default_of = 8'h20;
      3'd6:    default_of = 8'h04;
      default: default_of = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfg_copy_store.sv
module cfg_copy_store
  import cfg_bank_pkg::*;
#(
  parameter int         COPY_IDX   = 0,
  parameter logic [8:0] OFFSET_DEF = 9'h100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  byte_t            wr_val,
  input  logic             soft_rst,
  input  logic             flip_en,
  input  logic [1:0]       flip_copy,
  input  logic [IDX_W-1:0] flip_idx,
  input  logic [2:0]       flip_bit,
  output bank_t            q
);

  bank_t q_nxt;
  logic  upd;

  always_comb begin
    q_nxt = q;
    if (flip_en && (flip_copy == 2'(COPY_IDX)))
      q_nxt[flip_idx][flip_bit] = ~q[flip_idx][flip_bit];
    if (wr_en)
      q_nxt[wr_idx] = wr_val;
    if (soft_rst)
      for (int i = 0; i < NREG; i++)
        q_nxt[i] = default_of(IDX_W'(i), OFFSET_DEF);
  end

  assign upd = wr_en | soft_rst | flip_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++)
        q[i] <= default_of(IDX_W'(i), OFFSET_DEF);
    end else if (upd) begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/cfg_vote.sv
module cfg_vote
  import cfg_bank_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  bank_t cp_a,
  input  bank_t cp_b,
  input  bank_t cp_c,
  output bank_t voted,
  output logic  mismatch
);

  always_comb begin
    voted = (cp_a & cp_b) | (cp_a & cp_c) | (cp_b & cp_c);
    mismatch = |((cp_a ^ cp_b) | (cp_a ^ cp_c));
  end

  // R2: reserved one bit of register 5 survives any single-copy upset
  a_r2_rsv_one_held: assert property (@(posedge clk) disable iff (!rst_n)
    voted[5][5] == 1'b1);

  // R2: reserved zero bits of register 1 never read back set
  a_r2_rsv_zero_held: assert property (@(posedge clk) disable iff (!rst_n)
    voted[1][2:0] == 3'b000);

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfg_bank_pkg::*;
#(
  parameter logic [7:0] ID_BASE  = 8'h17,
  parameter logic [7:0] REV_ADDR = 8'h1F,
  parameter logic [7:0] TMP_ADDR = 8'h08,
  parameter logic [7:0] ERR_ADDR = 8'h09
) (
  input  logic [7:0]  addr,
  input  bank_t       voted,
  input  logic        err,
  input  logic [7:0]  temp_code,
  input  logic [63:0] die_id,
  input  logic [7:0]  die_rev,
  output logic [7:0]  rdata
);

  localparam int NID = 8;

  logic [7:0] id_off;
  logic       id_hit;

  assign id_off = addr - ID_BASE;
  assign id_hit = (addr >= ID_BASE) && (id_off < 8'(NID));

  always_comb begin
    rdata = 8'h00;
    if (addr < 8'(NREG))
      rdata = voted[addr[IDX_W-1:0]];
    else if (addr == TMP_ADDR)
      rdata = temp_code;
    else if (addr == ERR_ADDR)
      rdata = {7'b0, err};
    else if (id_hit)
      rdata = die_id[id_off[2:0]*8 +: 8];
    else if (addr == REV_ADDR)
      rdata = die_rev;
  end

endmodule

// File: rtl/cfg_triplex_bank.sv
module cfg_triplex_bank
  import cfg_bank_pkg::*;
#(
  parameter logic [8:0] OFFSET_DEF = 9'h100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  input  logic        reg_we,
  output logic [7:0]  reg_rdata,
  input  logic [7:0]  temp_code,
  input  logic [63:0] die_id,
  input  logic [7:0]  die_rev,
  input  logic        tamper_en,
  input  logic [1:0]  tamper_copy,
  input  logic [2:0]  tamper_reg,
  input  logic [2:0]  tamper_bit,
  output logic        copy_err,
  output logic [11:0] gain_trim,
  output logic        four_wire
);

  localparam logic [7:0] CTRL_ADDR = 8'h01;
  localparam int         SRST_BIT  = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  // write decode
  logic             wr_hit, soft_rst, wr_en;
  logic [IDX_W-1:0] wr_idx;
  byte_t            wr_val;

  always_comb begin
    wr_hit   = reg_we && (reg_addr < 8'(NREG));
    wr_idx   = reg_addr[IDX_W-1:0];
    soft_rst = wr_hit && (reg_addr == CTRL_ADDR) && reg_wdata[SRST_BIT];
    wr_en    = wr_hit && !soft_rst;
    wr_val   = (reg_wdata & ~clr_mask(wr_idx)) | set_mask(wr_idx);
  end

  bank_t cp [NCOPY];

  for (genvar g = 0; g < NCOPY; g++) begin : g_copy
    cfg_copy_store #(
      .COPY_IDX  (g),
      .OFFSET_DEF(OFFSET_DEF)
    ) u_store (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_val   (wr_val),
      .soft_rst (soft_rst),
      .flip_en  (tamper_en),
      .flip_copy(tamper_copy),
      .flip_idx (tamper_reg),
      .flip_bit (tamper_bit),
      .q        (cp[g])
    );
  end

  bank_t voted;

  cfg_vote u_vote (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .cp_a    (cp[0]),
    .cp_b    (cp[1]),
    .cp_c    (cp[2]),
    .voted   (voted),
    .mismatch(copy_err)
  );

  cfg_read_mux u_rmux (
    .addr     (reg_addr),
    .voted    (voted),
    .err      (copy_err),
    .temp_code(temp_code),
    .die_id   (die_id),
    .die_rev  (die_rev),
    .rdata    (reg_rdata)
  );

  assign gain_trim = {voted[0], voted[1][7:4]};
  assign four_wire = voted[1][3];

  // R3: soft reset returns the exported fields to their defaults
  a_r3_soft_reset: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_we && reg_addr == CTRL_ADDR && reg_wdata[SRST_BIT])
      |=> (gain_trim == 12'h000 && !four_wire));

  // R4: writes above the writable range leave the exported fields alone
  a_r4_ro_write_ignored: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_we && reg_addr >= 8'(NREG) && !tamper_en)
      |=> ($stable(gain_trim) && $stable(four_wire)));

  // R6: a plain write to register 0 lands in the top of the gain word
  a_r6_gain_high: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_we && reg_addr == 8'h00 && !tamper_en)
      |=> (gain_trim[11:4] == $past(reg_wdata)));

  // R8: disagreement never appears without a flip
  a_r8_no_spont_err: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!tamper_en && !copy_err) |=> !copy_err);

endmodule

// File: tb/cfg_triplex_bank_tb_top.sv
`timescale 1ns/1ps
module cfg_triplex_bank_tb_top;

  localparam logic [8:0] OFFSET_DEF = 9'h100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  reg_addr, reg_wdata, reg_rdata, temp_code, die_rev;
  logic        reg_we, tamper_en, copy_err, four_wire;
  logic [63:0] die_id;
  logic [1:0]  tamper_copy;
  logic [2:0]  tamper_reg, tamper_bit;
  logic [11:0] gain_trim;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_reg [8];

  always #5 clk = ~clk;

  cfg_triplex_bank #(.OFFSET_DEF(OFFSET_DEF)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .temp_code(temp_code),
    .die_id(die_id), .die_rev(die_rev), .tamper_en(tamper_en),
    .tamper_copy(tamper_copy), .tamper_reg(tamper_reg), .tamper_bit(tamper_bit),
    .copy_err(copy_err), .gain_trim(gain_trim), .four_wire(four_wire)
  );

  function automatic logic [7:0] dflt(input int i);
    case (i)
      3: dflt = {7'b0, OFFSET_DEF[8]};
      4: dflt = OFFSET_DEF[7:0];
      5: dflt = 8'h20;
      6: dflt = 8'h04;
      default: dflt = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] stored(input int i, input logic [7:0] d);
    case (i)
      1: stored = d & 8'hF8;
      2: stored = d & 8'hFB;
      3: stored = d & 8'hFD;
      5: stored = (d & 8'hFE) | 8'h20;
      default: stored = d;
    endcase
  endfunction

  function automatic logic [7:0] map_exp(input int a);
    if (a < 8) map_exp = exp_reg[a];
    else if (a == 8) map_exp = temp_code;
    else if (a == 9) map_exp = 8'h00;
    else if (a >= 8'h17 && a <= 8'h1E) map_exp = die_id[(a - 8'h17)*8 +: 8];
    else if (a == 8'h1F) map_exp = die_rev;
    else map_exp = 8'h00;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #2 d = reg_rdata;
  endtask

  task automatic check_all_regs(input string req);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(8'(i), v);
      check(req, {24'b0, v}, {24'b0, exp_reg[i]});
    end
  endtask

  task automatic check_fields(input string req);
    check(req, {20'b0, gain_trim}, {20'b0, exp_reg[0], exp_reg[1][7:4]});
    check(req, {31'b0, four_wire}, {31'b0, exp_reg[1][3]});
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] pats [8];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h5A;
    pats[4] = 8'h01; pats[5] = 8'h80; pats[6] = 8'h3C; pats[7] = 8'hC3;

    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 8'h00; reg_wdata = 8'h00;
    tamper_en = 1'b0; tamper_copy = 2'd3; tamper_reg = 3'd0; tamper_bit = 3'd0;
    temp_code = 8'h73; die_rev = 8'h2B; die_id = 64'h0123_4567_89AB_CDEF;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    for (int i = 0; i < 8; i++) exp_reg[i] = dflt(i);
    check_all_regs("R1");
    check("R1 copy_err", {31'b0, copy_err}, 32'd0);
    check_fields("R1/R6");

    // R2 / R6 write sweep with reserved bits
    for (int i = 0; i < 8; i++) begin
      for (int p = 0; p < 8; p++) begin
        logic [7:0] d;
        d = (i == 1) ? (pats[p] & 8'hFB) : pats[p];
        wr(8'(i), d);
        exp_reg[i] = stored(i, d);
        rd(8'(i), v);
        check("R2", {24'b0, v}, {24'b0, exp_reg[i]});
        check_fields("R6");
      end
    end
    for (int i = 0; i < 8; i++) begin
      wr(8'(i), 8'(i * 37 + 11) & ((i == 1) ? 8'hFB : 8'hFF));
      exp_reg[i] = stored(i, 8'(i * 37 + 11) & ((i == 1) ? 8'hFB : 8'hFF));
    end
    check_all_regs("R2");
    check_fields("R6");

    // R4 writes to read-only and unmapped space ignored; full map read R5
    for (int a = 8; a < 256; a++) wr(8'(a), 8'hFF);
    check_all_regs("R4");
    check_fields("R4");
    for (int a = 0; a < 256; a++) begin
      rd(8'(a), v);
      check((a < 8) ? "R4" : "R5/R4 map", {24'b0, v}, {24'b0, map_exp(a)});
    end
    temp_code = 8'hAF;
    rd(8'h08, v);
    check("R5 temp", {24'b0, v}, 32'hAF);

    // R7 / R8 single-bit flips in every copy, register, bit
    for (int c = 0; c < 3; c++)
      for (int r = 0; r < 8; r++)
        for (int b = 0; b < 8; b++) begin
          @(negedge clk);
          tamper_en = 1'b1; tamper_copy = 2'(c); tamper_reg = 3'(r); tamper_bit = 3'(b);
          @(negedge clk);
          tamper_en = 1'b0;
          check("R7 err", {31'b0, copy_err}, 32'd1);
          rd(8'(r), v);
          check("R7 vote", {24'b0, v}, {24'b0, exp_reg[r]});
          check_fields("R7 fields");
          rd(8'h09, v);
          check("R5 err reg", {24'b0, v}, 32'd1);
          wr(8'(r), exp_reg[r]);
          check("R8 clear", {31'b0, copy_err}, 32'd0);
        end

    // R7 copy select 3 touches nothing
    @(negedge clk);
    tamper_en = 1'b1; tamper_copy = 2'd3; tamper_reg = 3'd0; tamper_bit = 3'd0;
    @(negedge clk);
    tamper_en = 1'b0;
    check("R7 none", {31'b0, copy_err}, 32'd0);

    // R8 two copies flipped differently, then rewrite clears
    @(negedge clk);
    tamper_en = 1'b1; tamper_copy = 2'd0; tamper_reg = 3'd6; tamper_bit = 3'd1;
    @(negedge clk);
    tamper_copy = 2'd2; tamper_reg = 3'd7; tamper_bit = 3'd4;
    @(negedge clk);
    tamper_en = 1'b0;
    check("R7 two regs", {31'b0, copy_err}, 32'd1);
    wr(8'h06, exp_reg[6]);
    check("R8 partial", {31'b0, copy_err}, 32'd1);
    wr(8'h07, exp_reg[7]);
    check("R8 both", {31'b0, copy_err}, 32'd0);

    // R3 soft reset
    wr(8'h00, 8'hAB);
    wr(8'h05, 8'hFF);
    wr(8'h01, 8'hFC);
    for (int i = 0; i < 8; i++) exp_reg[i] = dflt(i);
    check_all_regs("R3");
    check_fields("R3");
    check("R3 err", {31'b0, copy_err}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule